// File: doc/BRIEF.md
# Reload-Match Timer PWM Generator

The block is an up-counting timer that drives one PWM pin. The counter is preloaded with a reload value and counts up to the all-ones maximum of its width. On the cycle after the maximum it reloads. The reload value therefore sets the period. A match value sets how long the output stays at its active level. The output is active from the reload cycle up to and including the cycle on which the counter equals the match value. It is inactive from there until the wrap.

Software writes a new setting through a single write port. In raw mode the two data words are the reload and match values, used as they are. In cycle mode the two words are a period length and an active length, both counted in clock cycles. A front end converts them into reload and match values and clamps the active length into its legal range. A write that would break the timer's constraints is rejected with a one-cycle error pulse, and the stored settings stay as they were. Accepted settings wait in a staging register. While the timer runs, they replace the active settings only at a period boundary.

A polarity input selects whether the active level is high or low. A wrap pulse marks the last cycle of every period.

Top module: `rmp_pwm_top`

## Requirements
- R1: While enabled, the counter steps up by one each cycle from the active reload value. The cycle after it holds all ones, it holds the reload value again, so a period lasts MAX − reload + 1 cycles (MAX = all ones). `wrap_pulse` is high exactly on the cycle the counter holds MAX.
- R2: In each period the output is at its active level for match − reload + 1 cycles, beginning with the cycle that holds the reload value. It is inactive for the remaining MAX − match cycles.
- R3: A write with `wr_mode` = 0 takes `wr_a` as the reload and `wr_b` as the match. It is accepted only if reload ≤ match and match ≠ MAX. Otherwise `cfg_err` is high for one cycle, on the cycle after the write, and the stored settings are unchanged.
- R4: A write with `wr_mode` = 1 takes `wr_a` as a period length P and `wr_b` as an active length D. It is rejected (same `cfg_err` behaviour as R3, settings unchanged) when P < 2.
- R5: An accepted cycle-mode write yields reload = MAX − P + 1 and match = reload + D − 1, giving a period of P cycles and D active cycles.
- R6: In cycle mode an active length of 0 is raised to 1. An active length of P or more is lowered to P − 1, so every period keeps at least one inactive cycle.
- R7: A setting accepted while the timer runs takes effect only at the first wrap after the write cycle. The period in progress completes with its old length and active time.
- R8: While `en` is low, the output sits at its inactive level and `wrap_pulse` stays low. Settings written meanwhile are the ones used once enabled. The first cycle after `en` is sampled high holds the reload value, with the output active.
- R9: `pol_inv` = 1 makes the active level low and the inactive level high, including the idle level while disabled.
- R10: After reset the settings are reload = match = MAX − 1 (a 2-cycle period with 1 active cycle), the timer is disabled, the output is inactive, and `cfg_err` and `wrap_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable |
| pol_inv | input | 1 | 1 = active level is low |
| wr_en | input | 1 | Write strobe for one setting |
| wr_mode | input | 1 | 0 = raw reload/match, 1 = period/active cycle counts |
| wr_a | input | W | Reload value or period length |
| wr_b | input | W | Match value or active length |
| pwm_out | output | 1 | PWM pin |
| wrap_pulse | output | 1 | High on the last cycle of each period |
| cfg_err | output | 1 | One-cycle pulse for a rejected write |

## Verification
The period and active time are measured between wrap pulses for several settings:
- the reset default of 2 cycles;
- a raw pair with a wide active window;
- cycle-mode pairs of different lengths.

Together these separate reload-based from match-based errors and off-by-one slips at each end. The clamp cases are a zero active length, an oversize active length and the minimum period. Each shows whether the front end clamps, derives or rejects correctly. Illegal raw pairs and a too-short period are followed by a measurement that proves the old setting survived. A write placed in mid-period tells a deferred commit from an immediate one. Disable, re-enable and inverted-polarity runs separate the idle level from the active level.

// File: rtl/rmp_pkg.sv
package rmp_pkg;
    typedef enum logic {
        WR_RAW = 1'b0,
        WR_CYC = 1'b1
    } wr_mode_e;
endpackage

// File: rtl/rmp_cfg_front.sv
// Decodes one setting write: raw reload/match or period/active cycle counts.
module rmp_cfg_front #(
    parameter int W = 32
) (
    input  logic         mode,
    input  logic [W-1:0] arg_a,
    input  logic [W-1:0] arg_b,
    output logic         ok,
    output logic [W-1:0] load_o,
    output logic [W-1:0] match_o
);
    import rmp_pkg::*;
    localparam logic [W-1:0] MAX = '1;
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    wr_mode_e     kind;
    logic [W-1:0] act_len;
    logic [W-1:0] cyc_load;

    always_comb begin
        kind = wr_mode_e'(mode);
        // clamp active length into [1, P-1]
        if (arg_b == '0)
            act_len = ONE;
        else if (arg_b >= arg_a)
            act_len = arg_a - ONE;
        else
            act_len = arg_b;
        cyc_load = MAX - arg_a + ONE;
        if (kind == WR_CYC) begin
            ok      = (arg_a >= TWO);
            load_o  = cyc_load;
            match_o = cyc_load + act_len - ONE;
        end else begin
            ok      = (arg_a <= arg_b) && (arg_b != MAX);
            load_o  = arg_a;
            match_o = arg_b;
        end
    end
endmodule

// File: rtl/rmp_cfg_stage.sv
// Staging register for accepted settings plus the reject pulse.
module rmp_cfg_stage #(
    parameter int           W         = 32,
    parameter logic [W-1:0] RST_LOAD  = '0,
    parameter logic [W-1:0] RST_MATCH = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         ok,
    input  logic [W-1:0] load_in,
    input  logic [W-1:0] match_in,
    output logic [W-1:0] pend_load,
    output logic [W-1:0] pend_match,
    output logic         err
);
    typedef struct packed {
        logic [W-1:0] ld;
        logic [W-1:0] mt;
        logic         err;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr_en) begin
            if (ok) begin
                st_d.ld = load_in;
                st_d.mt = match_in;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ld  <= RST_LOAD;
            st_q.mt  <= RST_MATCH;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_load  = st_q.ld;
    assign pend_match = st_q.mt;
    assign err        = st_q.err;
endmodule

// File: rtl/rmp_cycle_ctr.sv
// Up counter with reload at wrap; active settings commit only at wrap or while idle.
module rmp_cycle_ctr #(
    parameter int           W         = 32,
    parameter logic [W-1:0] RST_LOAD  = '0,
    parameter logic [W-1:0] RST_MATCH = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] pend_load,
    input  logic [W-1:0] pend_match,
    output logic         run,
    output logic [W-1:0] cnt,
    output logic [W-1:0] act_load,
    output logic [W-1:0] act_match,
    output logic         wrap
);
    localparam logic [W-1:0] MAX = '1;

    typedef struct packed {
        logic         run;
        logic [W-1:0] cnt;
        logic [W-1:0] ld;
        logic [W-1:0] mt;
    } ctr_t;

    ctr_t c_d, c_q;
    logic at_top;

    always_comb begin
        c_d    = c_q;
        c_d.run = en;
        at_top = c_q.run && (c_q.cnt == MAX);
        if (!c_q.run || at_top) begin
            c_d.cnt = pend_load;
            c_d.ld  = pend_load;
            c_d.mt  = pend_match;
        end else begin
            c_d.cnt = c_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.run <= 1'b0;
            c_q.cnt <= RST_LOAD;
            c_q.ld  <= RST_LOAD;
            c_q.mt  <= RST_MATCH;
        end else begin
            c_q <= c_d;
        end
    end

    assign run       = c_q.run;
    assign cnt       = c_q.cnt;
    assign act_load  = c_q.ld;
    assign act_match = c_q.mt;
    assign wrap      = at_top;
endmodule

// File: rtl/rmp_out_stage.sv
// Active window compare and polarity.
module rmp_out_stage #(
    parameter int W = 32
) (
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] act_match,
    input  logic         pol_inv,
    output logic         pwm
);
    logic active;
    always_comb begin
        active = run && (cnt <= act_match);
        pwm    = active ^ pol_inv;
    end
endmodule

// File: rtl/rmp_pwm_top.sv
module rmp_pwm_top #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         pol_inv,
    input  logic         wr_en,
    input  logic         wr_mode,
    input  logic [W-1:0] wr_a,
    input  logic [W-1:0] wr_b,
    output logic         pwm_out,
    output logic         wrap_pulse,
    output logic         cfg_err
);
    localparam logic [W-1:0] MAX       = '1;
    localparam logic [W-1:0] RST_LOAD  = MAX - W'(1);
    localparam logic [W-1:0] RST_MATCH = MAX - W'(1);

    logic         dec_ok;
    logic [W-1:0] dec_load, dec_match;
    logic [W-1:0] pend_load, pend_match;
    logic         run;
    logic [W-1:0] cnt, act_load, act_match;

    rmp_cfg_front #(.W(W)) front_i (
        .mode    (wr_mode),
        .arg_a   (wr_a),
        .arg_b   (wr_b),
        .ok      (dec_ok),
        .load_o  (dec_load),
        .match_o (dec_match)
    );

    rmp_cfg_stage #(.W(W), .RST_LOAD(RST_LOAD), .RST_MATCH(RST_MATCH)) stage_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .ok         (dec_ok),
        .load_in    (dec_load),
        .match_in   (dec_match),
        .pend_load  (pend_load),
        .pend_match (pend_match),
        .err        (cfg_err)
    );

    rmp_cycle_ctr #(.W(W), .RST_LOAD(RST_LOAD), .RST_MATCH(RST_MATCH)) ctr_i (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .pend_load  (pend_load),
        .pend_match (pend_match),
        .run        (run),
        .cnt        (cnt),
        .act_load   (act_load),
        .act_match  (act_match),
        .wrap       (wrap_pulse)
    );

    rmp_out_stage #(.W(W)) out_i (
        .run       (run),
        .cnt       (cnt),
        .act_match (act_match),
        .pol_inv   (pol_inv),
        .pwm       (pwm_out)
    );
endmodule

// File: rtl/rmp_pwm_checker.sv
module rmp_pwm_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         pol_inv,
    input logic         pwm_out,
    input logic         wrap_pulse,
    input logic         cfg_err,
    input logic         run,
    input logic [W-1:0] cnt,
    input logic [W-1:0] act_load,
    input logic [W-1:0] act_match,
    input logic [W-1:0] pend_load,
    input logic [W-1:0] pend_match
);
    localparam logic [W-1:0] MAX = '1;

    AST_CNT_ABOVE_LOAD: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt >= act_load); // R1
    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        run && en && !wrap_pulse |=> cnt == $past(cnt) + W'(1)); // R1
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse && en |=> cnt == $past(pend_load)); // R1
    AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (act_load <= act_match) && (act_match != MAX)); // R3
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $stable(pend_load) && $stable(pend_match)); // R3
    AST_COMMIT_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        run && en && !wrap_pulse |=> $stable(act_load) && $stable(act_match)); // R7
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !run |-> (pwm_out == pol_inv) && !wrap_pulse); // R8
    AST_START_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
        run && !$past(run) |-> cnt == act_load && pwm_out != pol_inv); // R8
endmodule

bind rmp_pwm_top rmp_pwm_checker #(.W(W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .pol_inv    (pol_inv),
    .pwm_out    (pwm_out),
    .wrap_pulse (wrap_pulse),
    .cfg_err    (cfg_err),
    .run        (run),
    .cnt        (cnt),
    .act_load   (act_load),
    .act_match  (act_match),
    .pend_load  (pend_load),
    .pend_match (pend_match)
);

// File: tb/rmp_pwm_top_tb_top.sv
module rmp_pwm_top_tb_top;
    localparam int W = 32;
    localparam logic [W-1:0] MAX = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         pol_inv = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_mode = 1'b0;
    logic [W-1:0] wr_a = '0;
    logic [W-1:0] wr_b = '0;
    logic         pwm_out, wrap_pulse, cfg_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    rmp_pwm_top #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .en(en), .pol_inv(pol_inv),
        .wr_en(wr_en), .wr_mode(wr_mode), .wr_a(wr_a), .wr_b(wr_b),
        .pwm_out(pwm_out), .wrap_pulse(wrap_pulse), .cfg_err(cfg_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            bad = bad + 1;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic mode, input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic exp_err, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_mode = mode; wr_a = a; wr_b = b;
        @(negedge clk);
        wr_en = 1'b0;
        check(req, cfg_err, exp_err);
    endtask

    task automatic wait_wrap();
        for (int n = 0; n < 2000 && !wrap_pulse; n++) @(negedge clk);
    endtask

    task automatic run_period(output int per, output int act);
        logic lvl;
        lvl = ~pol_inv;
        per = 0; act = 0;
        do begin
            @(negedge clk);
            per++;
            if (pwm_out === lvl) act++;
        end while (!wrap_pulse && per < 5000);
    endtask

    // skip one full period so any pending setting is committed, then measure
    task automatic measure(input int exp_per, input int exp_act, input string req);
        int p, a;
        wait_wrap();
        run_period(p, a);
        run_period(p, a);
        check({req, " period"}, p, exp_per);
        check({req, " active"}, a, exp_act);
    endtask

    task automatic t_reset();
        check("R10 pwm idle", pwm_out, 0);
        check("R10 wrap low", wrap_pulse, 0);
        check("R10 err low", cfg_err, 0);
        @(negedge clk); en = 1'b1;
        measure(2, 1, "R10 default");
    endtask

    task automatic t_raw();
        do_write(1'b0, MAX - 9, MAX - 5, 1'b0, "R3 raw accept");
        measure(10, 5, "R1 R2 raw");
        do_write(1'b0, MAX - 9, MAX - 9, 1'b0, "R3 raw load=match");
        measure(10, 1, "R2 raw minimum active");
    endtask

    task automatic t_raw_reject();
        do_write(1'b0, MAX - 3, MAX, 1'b1, "R3 match=MAX reject");
        do_write(1'b0, MAX - 3, MAX - 5, 1'b1, "R3 load>match reject");
        measure(10, 1, "R3 settings kept");
    endtask

    task automatic t_cycle();
        do_write(1'b1, 12, 7, 1'b0, "R5 cycle accept");
        measure(12, 7, "R5 cycle");
        do_write(1'b1, 2, 1, 1'b0, "R5 minimum period");
        measure(2, 1, "R5 minimum period");
    endtask

    task automatic t_clamp();
        do_write(1'b1, 5, 0, 1'b0, "R6 zero active");
        measure(5, 1, "R6 zero active");
        do_write(1'b1, 5, 9, 1'b0, "R6 oversize active");
        measure(5, 4, "R6 oversize active");
        do_write(1'b1, 1, 1, 1'b1, "R4 short period reject");
        do_write(1'b1, 0, 0, 1'b1, "R4 zero period reject");
        measure(5, 4, "R4 settings kept");
    endtask

    task automatic t_midperiod();
        int p, a;
        do_write(1'b1, 10, 3, 1'b0, "R7 setup");
        measure(10, 3, "R7 before");
        wait_wrap();
        p = 0; a = 0;
        do begin
            @(negedge clk);
            p++;
            if (pwm_out === 1'b1) a++;
            if (p == 3) begin wr_en = 1'b1; wr_mode = 1'b1; wr_a = 6; wr_b = 2; end
            if (p == 4) wr_en = 1'b0;
        end while (!wrap_pulse && p < 5000);
        check("R7 running period kept", p, 10);
        check("R7 running active kept", a, 3);
        run_period(p, a);
        check("R7 next period", p, 6);
        check("R7 next active", a, 2);
    endtask

    task automatic t_disable();
        int hi;
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        hi = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (pwm_out !== 1'b0 || wrap_pulse !== 1'b0) hi++;
        end
        check("R8 idle outputs", hi, 0);
        do_write(1'b0, MAX - 3, MAX - 3, 1'b0, "R8 write while idle");
        check("R8 idle after write", pwm_out, 0);
        en = 1'b1;
        @(negedge clk);
        check("R8 first enabled cycle active", pwm_out, 1);
        measure(4, 1, "R8 idle setting used");
    endtask

    task automatic t_polarity();
        @(negedge clk); en = 1'b0; pol_inv = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 inverted idle level", pwm_out, 1);
        do_write(1'b1, 8, 3, 1'b0, "R9 setup");
        en = 1'b1;
        measure(8, 3, "R9 inverted active low");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_raw();
        t_raw_reject();
        t_cycle();
        t_clamp();
        t_midperiod();
        t_disable();
        t_polarity();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule